// File: doc/BRIEF.md
# Carrier-Modulated Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for use inside a larger chip. One of four incoming clock-enable pulse trains is chosen as the source. A prescaler scales that source to an operating tick. A bit is then 4 or 16 operating ticks long. The transmitter serializes bytes offered on a valid/ready interface. The receiver recovers characters from the serial input and reports each one with a single-clock valid pulse and two error flags.

The framing is configurable:
- 7 or 8 data bits, sent least significant bit first.
- Optional odd or even parity.
- One or two stop bits.

The line idles high before any pin inversion. An optional modulator can replace either the high or the low portion of the transmit waveform with a locally generated square-wave carrier, for example to drive an infrared emitter. Separate bits invert the transmit pin, after modulation, and the receive pin, before sampling.

Software-side configuration goes through a small word-wide register port:
- Address 0 (control): bit 0 is the run enable.
- Address 1 (clock): bits [1:0] select the source and bits [5:4] select the divide code.
- Address 2 (mode): see R3 to R7.
- Address 3 (carrier): holds the carrier half-period.

Top module: `uart_carrier`

## Requirements
- R1: The operating tick follows only pulses of `src_tick[src]`. For sources 0 and 2, divide codes 0/1/2/3 give ratios 1/2/4/8. For sources 1 and 3, code 2 gives 4 and every other code gives 1.
- R2: A write to the clock register (address 1) is ignored while the run enable (address 0, bit 0) is 1, and takes effect while it is 0.
- R3: Mode bit 2 set makes a bit last 4 operating ticks; when it is clear, a bit lasts 16 operating ticks.
- R4: A transmitted frame is one low start bit, then 7 data bits (mode bit 5 set) or 8 data bits, LSB first. Next comes a parity bit if mode bit 6 is set: the XOR of the data bits, inverted when mode bit 7 is set. The frame ends with one high stop bit, or two when mode bit 8 is set.
- R5: With mode bit 1 clear, the un-inverted transmit pin is the plain frame level, high when idle.
- R6: With mode bit 1 set, the carrier toggles every (address 3 value + 1) operating ticks. If mode bit 0 is set, the pin shows the carrier while the data is high and is low while the data is low. If mode bit 0 is clear, the pin shows the carrier while the data is low and is high while the data is high.
- R7: Mode bit 4 inverts `tx_pin` after modulation; mode bit 3 inverts `rx_pin` before sampling.
- R8: For each received frame, `rx_valid` pulses high for exactly one clock, with `rx_data` holding the data bits. A 7-bit character has bit 7 as 0.
- R9: `rx_frame_err` is 1 with `rx_valid` when the first stop bit is sampled low, otherwise 0.
- R10: `rx_par_err` is 1 with `rx_valid` when parity is enabled and the received parity bit mismatches R4, otherwise 0.
- R11: Register reads return 0 in every bit that is not defined: above bit 0 of control, bits 3:2 and 15:6 of clock, bits 15:9 of mode, and bits 15:8 of carrier.
- R12: `tx_ready` is 1 only while the run enable is set and no frame is in progress. A byte is taken when `tx_valid` and `tx_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| src_tick | input | 4 | Clock-enable pulse train for each clock source |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_pin | output | 1 | Serial transmit pin |
| rx_pin | input | 1 | Serial receive pin |
| rx_valid | output | 1 | One-clock pulse per received character |
| rx_data | output | 8 | Received character |
| rx_frame_err | output | 1 | Stop bit was low |
| rx_par_err | output | 1 | Parity mismatch |

## Verification
The assertions assume three things:
- The mode and carrier registers are not rewritten while a frame is in flight.
- The transmit data is held valid until it is taken.
- The serial input changes only at bit boundaries longer than the receiver's synchronizer latency.

The stimulus keeps to these assumptions. It reprograms the mode only between frames, then waits several bit times so that any spurious start caused by an inversion change has settled. It drives receive bits whole-bit wide from its own model. Random framing, inversion and sample-ratio settings are drawn from a fixed seed. They are mixed with directed cases for clock-source ratios, the register lock, reserved-bit reads, carrier behaviour, stop-bit count, framing errors and parity errors.

// File: rtl/uart_carrier_pkg.sv
// Shared types and helpers for the carrier-modulated serial port.
// Assumes a single clock domain; all rates are derived from clock enables.
package uart_carrier_pkg;

    localparam int N_SRC   = 4;               // clock-source inputs
    localparam int SEL_W   = $clog2(N_SRC);   // source select width
    localparam int PRE_W   = 3;               // prescaler counter width (up to 1/8)
    localparam int DATA_W  = 8;               // widest character
    localparam int CNT_W   = 4;               // per-bit tick counter width
    localparam int LAST_HI = 15;              // last tick of a 16-tick bit
    localparam int LAST_LO = 3;               // last tick of a 4-tick bit
    localparam int MID_HI  = 6;               // centre of the 3-sample vote window (16x)
    localparam int MID_LO  = 1;               // single sample point (4x)
    localparam int REG_W   = 16;              // register data width

    // Frame phase shared by transmitter and receiver
    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
    } phase_t;

    // Mode register layout, MSB first (bit 8 .. bit 0)
    typedef struct packed {
        logic two_stop;    // bit 8
        logic odd_par;     // bit 7
        logic par_on;      // bit 6
        logic short_char;  // bit 5: 7 data bits
        logic flip_tx;     // bit 4
        logic flip_rx;     // bit 3
        logic fast_bit;    // bit 2: 4 ticks per bit
        logic car_on;      // bit 1
        logic car_on_high; // bit 0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // Parity bit for a character: even parity unless odd is requested
    function automatic logic frame_parity(input logic [DATA_W-1:0] d,
                                          input logic short_char,
                                          input logic odd);
        logic x;
        x = short_char ? ^d[DATA_W-2:0] : ^d;
        return x ^ odd;
    endfunction

    // Index of the last data bit for the chosen character length
    function automatic logic [2:0] last_data_idx(input logic short_char);
        return short_char ? 3'(DATA_W - 2) : 3'(DATA_W - 1);
    endfunction

endpackage

// File: rtl/uc_clkgen.sv
// Clock-source select and prescaler.
// Picks one of the source enable trains and divides it to an operating tick.
// Assumes select and divide are stable while run is high.
module uc_clkgen
    import uart_carrier_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [1:0]       div_sel,
    output logic             op_tick
);

    logic             sel_tick;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;

    assign sel_tick = src_tick[src_sel];

    // Divide mask: full range on even sources, 1/1 or 1/4 on odd sources
    always_comb begin
        if (src_sel[0]) begin
            mask = (div_sel == 2'd2) ? 3'd3 : 3'd0;
        end else begin
            case (div_sel)
                2'd0:    mask = 3'd0;
                2'd1:    mask = 3'd1;
                2'd2:    mask = 3'd3;
                default: mask = 3'd7;
            endcase
        end
    end

    // Prescaler counts pulses of the selected source
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_cnt <= '0;
        else if (sel_tick)  pre_cnt <= pre_cnt + 1'b1;
    end

    assign op_tick = run && sel_tick && ((pre_cnt & mask) == mask);

    AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        op_tick |-> src_tick[src_sel]);  // R1

endmodule

// File: rtl/uc_tx.sv
// Transmit serializer.
// Takes a byte on valid/ready and produces the un-modulated frame level.
// Assumes the mode is stable for the duration of a frame.
module uc_tx
    import uart_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              op_tick,
    input  mode_t             cfg,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              line_o
);

    phase_t            ph;
    logic [CNT_W-1:0]  tick_cnt;
    logic [DATA_W-1:0] shreg;
    logic [2:0]        idx;
    logic              par_q;
    logic              extra_stop;
    logic [CNT_W-1:0]  last_tick;
    logic              accept;

    assign last_tick = cfg.fast_bit ? CNT_W'(LAST_LO) : CNT_W'(LAST_HI);
    assign tx_ready  = run && (ph == PH_IDLE);
    assign accept    = tx_valid && tx_ready;

    // Frame sequencer: start, data, optional parity, one or two stops
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph         <= PH_IDLE;
            tick_cnt   <= '0;
            shreg      <= '0;
            idx        <= '0;
            par_q      <= 1'b0;
            extra_stop <= 1'b0;
        end else if (accept) begin
            ph         <= PH_START;
            tick_cnt   <= '0;
            shreg      <= tx_data;
            idx        <= '0;
            par_q      <= frame_parity(tx_data, cfg.short_char, cfg.odd_par);
            extra_stop <= cfg.two_stop;
        end else if (op_tick && ph != PH_IDLE) begin
            if (tick_cnt == last_tick) begin
                tick_cnt <= '0;
                case (ph)
                    PH_START: ph <= PH_DATA;
                    PH_DATA: begin
                        shreg <= shreg >> 1;
                        idx   <= idx + 1'b1;
                        if (idx == last_data_idx(cfg.short_char))
                            ph <= cfg.par_on ? PH_PAR : PH_STOP;
                    end
                    PH_PAR: ph <= PH_STOP;
                    PH_STOP: begin
                        if (extra_stop) extra_stop <= 1'b0;
                        else            ph         <= PH_IDLE;
                    end
                    default: ph <= PH_IDLE;
                endcase
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Line level for the current phase
    always_comb begin
        case (ph)
            PH_START: line_o = 1'b0;
            PH_DATA:  line_o = shreg[0];
            PH_PAR:   line_o = par_q;
            default:  line_o = 1'b1;
        endcase
    end

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(accept)) |-> (line_o == 1'b0));  // R4

endmodule

// File: rtl/uc_carrier.sv
// Carrier generator and modulator.
// A half-period counter on the operating tick makes a square wave that
// replaces either the high or the low portion of the frame level.
module uc_carrier
    import uart_carrier_pkg::*;
#(
    parameter int CAR_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             op_tick,
    input  logic             car_on,
    input  logic             car_on_high,
    input  logic [CAR_W-1:0] half_len,
    input  logic             data_i,
    output logic             mod_o
);

    logic [CAR_W-1:0] car_cnt;
    logic             carrier;

    // Square wave toggles every half_len+1 operating ticks
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !car_on) begin
            car_cnt <= '0;
            carrier <= 1'b0;
        end else if (op_tick) begin
            if (car_cnt == half_len) begin
                car_cnt <= '0;
                carrier <= ~carrier;
            end else begin
                car_cnt <= car_cnt + 1'b1;
            end
        end
    end

    // Carrier shows during the selected data level, steady level otherwise
    always_comb begin
        if (!car_on)          mod_o = data_i;
        else if (car_on_high) mod_o = data_i & carrier;
        else                  mod_o = data_i | carrier;
    end

    AST_CARRIER_LOWPHASE_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (car_on && !car_on_high && data_i) |-> mod_o);  // R6
    AST_CARRIER_HIGHPHASE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (car_on && car_on_high && !data_i) |-> !mod_o);  // R6

endmodule

// File: rtl/uc_rx.sv
// Receiver.
// Synchronizes the serial input, detects a falling edge, confirms the start
// bit at mid-bit and assembles a character. Uses a three-sample majority
// vote with 16 ticks per bit and a single sample with 4 ticks per bit.
module uc_rx
    import uart_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              op_tick,
    input  mode_t             cfg,
    input  logic              pin,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              frame_err,
    output logic              par_err
);

    logic              sync1, sync2, prev;
    logic              line;
    logic              fall;
    phase_t            ph;
    logic [CNT_W-1:0]  tick_cnt;
    logic [1:0]        votes;
    logic [DATA_W-1:0] shreg;
    logic [2:0]        idx;
    logic              par_rx;
    logic [CNT_W-1:0]  last_tick;
    logic              in_win;
    logic              bit_val;
    logic [DATA_W-1:0] char_w;

    assign line      = sync2 ^ cfg.flip_rx;
    assign fall      = prev && !line;
    assign last_tick = cfg.fast_bit ? CNT_W'(LAST_LO) : CNT_W'(LAST_HI);
    assign in_win    = cfg.fast_bit ? (tick_cnt == CNT_W'(MID_LO))
                                    : (tick_cnt >= CNT_W'(MID_HI - 1) &&
                                       tick_cnt <= CNT_W'(MID_HI + 1));
    assign bit_val   = cfg.fast_bit ? (votes != 2'd0) : (votes >= 2'd2);
    assign char_w    = cfg.short_char ? {1'b0, shreg[DATA_W-1:1]} : shreg;

    // Two-stage input synchronizer and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            prev  <= line;
        end
    end

    // Bit sampling and character assembly
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph        <= PH_IDLE;
            tick_cnt  <= '0;
            votes     <= '0;
            shreg     <= '0;
            idx       <= '0;
            par_rx    <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (ph == PH_IDLE) begin
                if (fall) begin
                    ph       <= PH_START;
                    tick_cnt <= '0;
                    votes    <= '0;
                end
            end else if (op_tick) begin
                if (in_win) votes <= votes + {1'b0, line};
                if (tick_cnt == last_tick) begin
                    tick_cnt <= '0;
                    votes    <= '0;
                    case (ph)
                        PH_START: begin
                            ph  <= bit_val ? PH_IDLE : PH_DATA;
                            idx <= '0;
                        end
                        PH_DATA: begin
                            shreg <= {bit_val, shreg[DATA_W-1:1]};
                            idx   <= idx + 1'b1;
                            if (idx == last_data_idx(cfg.short_char))
                                ph <= cfg.par_on ? PH_PAR : PH_STOP;
                        end
                        PH_PAR: begin
                            par_rx <= bit_val;
                            ph     <= PH_STOP;
                        end
                        default: begin
                            rx_valid  <= 1'b1;
                            rx_data   <= char_w;
                            frame_err <= !bit_val;
                            par_err   <= cfg.par_on &&
                                         (par_rx != frame_parity(char_w, cfg.short_char, cfg.odd_par));
                            ph        <= PH_IDLE;
                        end
                    endcase
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);  // R8
    AST_SHORT_CHAR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg.short_char) |-> !rx_data[DATA_W-1]);  // R8

endmodule

// File: rtl/uart_carrier.sv
// Top of the carrier-modulated serial port.
// Holds the configuration registers and joins the clock generator,
// transmitter, carrier modulator and receiver. Pin inversion is applied
// here, outside the modulator.
module uart_carrier
    import uart_carrier_pkg::*;
#(
    parameter int CAR_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             tx_pin,
    input  logic             rx_pin,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_frame_err,
    output logic             rx_par_err
);

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CLK  = 2'd1;
    localparam logic [1:0] A_MODE = 2'd2;
    localparam logic [1:0] A_CAR  = 2'd3;

    logic             run_q;
    logic [SEL_W-1:0] src_q;
    logic [1:0]       div_q;
    mode_t            mode_q;
    logic [CAR_W-1:0] half_q;
    logic             op_tick;
    logic             frame_lvl;
    logic             mod_lvl;

    // Register writes; the clock register is locked while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            src_q  <= '0;
            div_q  <= '0;
            mode_q <= '0;
            half_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: run_q <= reg_wdata[0];
                A_CLK: begin
                    if (!run_q) begin
                        src_q <= reg_wdata[SEL_W-1:0];
                        div_q <= reg_wdata[5:4];
                    end
                end
                A_MODE:  mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
                default: half_q <= reg_wdata[CAR_W-1:0];
            endcase
        end
    end

    // Read mux with undefined bits forced to zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[0] = run_q;
            A_CLK: begin
                reg_rdata[SEL_W-1:0] = src_q;
                reg_rdata[5:4]       = div_q;
            end
            A_MODE:  reg_rdata[MODE_W-1:0] = mode_q;
            default: reg_rdata[CAR_W-1:0]  = half_q;
        endcase
    end

    uc_clkgen u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .src_tick (src_tick),
        .src_sel  (src_q),
        .div_sel  (div_q),
        .op_tick  (op_tick)
    );

    uc_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .op_tick  (op_tick),
        .cfg      (mode_q),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .line_o   (frame_lvl)
    );

    uc_carrier #(.CAR_W(CAR_W)) u_carrier (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .op_tick     (op_tick),
        .car_on      (mode_q.car_on),
        .car_on_high (mode_q.car_on_high),
        .half_len    (half_q),
        .data_i      (frame_lvl),
        .mod_o       (mod_lvl)
    );

    assign tx_pin = mod_lvl ^ mode_q.flip_tx;

    uc_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .op_tick   (op_tick),
        .cfg       (mode_q),
        .pin       (rx_pin),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .frame_err (rx_frame_err),
        .par_err   (rx_par_err)
    );

    AST_CLOCK_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable({src_q, div_q}));  // R2
    AST_IDLE_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.car_on && tx_ready) |-> (tx_pin == !mode_q.flip_tx));  // R5

endmodule

// File: tb/uart_carrier_bench.sv
module uart_carrier_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  src_tick;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, tx_pin, rx_pin;
    logic        rx_valid, rx_frame_err, rx_par_err;
    logic [7:0]  rx_data;
    logic        loop_on = 1'b0;
    logic        drv_rx = 1'b1;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Source k pulses every k+1 clocks
    assign src_tick = {(cyc % 4) == 0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
    assign rx_pin   = loop_on ? tx_pin : drv_rx;

    uart_carrier u_uart_carrier (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_mode(input bit stop2, input bit odd, input bit pen,
                                            input bit len7, input bit itx, input bit irx,
                                            input bit fast, input bit car, input bit chigh);
        return {7'b0, stop2, odd, pen, len7, itx, irx, fast, car, chigh};
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input bit len7, input bit odd);
        logic [7:0] m;
        m = len7 ? (d & 8'h7F) : d;
        return (^m) ^ odd;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk); tx_data = d; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic cap_tx(input int T, input bit len7, input bit pen, input bit inv,
                          output logic [7:0] d, output logic p, output logic s, output bit ok);
        int g;
        g = 0; ok = 1; d = '0; p = 1'b0;
        @(negedge clk);
        while (((tx_pin ^ inv) != 1'b0) && g < 40*T) begin @(negedge clk); g++; end
        if (g >= 40*T) ok = 0;
        repeat (T/2) @(negedge clk);
        for (int i = 0; i < (len7 ? 7 : 8); i++) begin
            repeat (T) @(negedge clk);
            d[i] = tx_pin ^ inv;
        end
        if (pen) begin repeat (T) @(negedge clk); p = tx_pin ^ inv; end
        repeat (T) @(negedge clk);
        s = tx_pin ^ inv;
    endtask

    task automatic wait_rx(input int T, output bit got, output logic [7:0] d,
                           output logic fe, output logic pe);
        got = 0; d = '0; fe = 1'b0; pe = 1'b0;
        for (int k = 0; k < 30*T && !got; k++) begin
            @(negedge clk);
            if (rx_valid) begin got = 1; d = rx_data; fe = rx_frame_err; pe = rx_par_err; end
        end
    endtask

    task automatic drv_bit(input logic b, input bit inv, input int T);
        drv_rx = b ^ inv;
        repeat (T) @(negedge clk);
    endtask

    task automatic drive_rx(input int T, input logic [7:0] d, input bit len7, input bit pen,
                            input bit odd, input bit bad_par, input logic stop_v, input bit inv);
        @(negedge clk);
        drv_bit(1'b0, inv, T);
        for (int i = 0; i < (len7 ? 7 : 8); i++) drv_bit(d[i], inv, T);
        if (pen) drv_bit(exp_par(d, len7, odd) ^ bad_par, inv, T);
        drv_bit(stop_v, inv, T);
        drv_rx = 1'b1 ^ inv;
    endtask

    // Length in clocks of the first low run on tx_pin
    task automatic low_run(output int L);
        int g;
        g = 0; L = 0;
        @(negedge clk);
        while (tx_pin && g < 5000) begin @(negedge clk); g++; end
        while (!tx_pin && L < 5000) begin @(negedge clk); L++; end
    endtask

    task automatic ratio_case(input int src, input int dv, input int P, input string tag);
        int L, T;
        T = 4 * P;
        wr(0, 16'h0000);
        wr(1, 16'((dv << 4) | src));
        wr(2, mk_mode(0,0,0,0,0,0,1,0,0));
        wr(0, 16'h0001);
        repeat (2*T) @(negedge clk);
        fork send_tx(8'h00); low_run(L); join
        chk(L >= 9*T - P - 1 && L <= 9*T + 1, tag, L, 9*T);
        repeat (3*T) @(negedge clk);
    endtask

    task automatic count_toggles(input int n, output int t);
        logic last;
        t = 0;
        @(negedge clk); last = tx_pin;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_pin != last) t++;
            last = tx_pin;
        end
    endtask

    logic [15:0] rv;
    logic [7:0]  cd, gd, em;
    logic        cp, cs, gfe, gpe;
    bit          ok, got;
    bit          l7, pe, po, s2, fq, iv;
    int          T, L, tg;

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(tx_pin == 1'b1, "R5 reset idle pin", tx_pin, 1);
        chk(tx_ready == 1'b0, "R12 not ready while disabled", tx_ready, 0);
        chk(rx_valid == 1'b0, "R8 no valid at reset", rx_valid, 0);
        rd(2, rv); chk(rv == 16'h0, "R11 mode reset", rv, 0);

        // Reserved bits read zero
        wr(1, 16'hFFFF); rd(1, rv); chk(rv == 16'h0033, "R11 clock reg", rv, 16'h0033);
        wr(2, 16'hFFFF); rd(2, rv); chk(rv == 16'h01FF, "R11 mode reg", rv, 16'h01FF);
        wr(3, 16'hFFFF); rd(3, rv); chk(rv == 16'h00FF, "R11 carrier reg", rv, 16'h00FF);
        wr(0, 16'hFFFF); rd(0, rv); chk(rv == 16'h0001, "R11 control reg", rv, 1);

        // Clock register locked while running
        wr(0, 16'h0000); wr(1, 16'h0000);
        wr(0, 16'h0001); wr(1, 16'h0021);
        rd(1, rv); chk(rv == 16'h0000, "R2 write ignored while running", rv, 0);
        wr(0, 16'h0000); wr(1, 16'h0021);
        rd(1, rv); chk(rv == 16'h0021, "R2 write taken while stopped", rv, 16'h0021);

        // Clock source and divide ratios, 4 ticks per bit
        ratio_case(0, 0, 1, "R1 src0 div1");
        ratio_case(1, 2, 8, "R1 src1 code2 ratio4");
        ratio_case(2, 1, 6, "R1 src2 code1 ratio2");
        ratio_case(3, 3, 4, "R1 src3 code3 ratio1");
        ratio_case(0, 3, 8, "R1 src0 code3 ratio8");

        // Back to the fastest source, 1 tick per clock
        wr(0, 16'h0000); wr(1, 16'h0000); wr(0, 16'h0001);

        // Ticks per bit
        wr(2, mk_mode(0,0,0,0,0,0,0,0,0)); repeat (40) @(negedge clk);
        fork send_tx(8'h00); low_run(L); join
        chk(L >= 9*16 - 1 && L <= 9*16 + 1, "R3 sixteen ticks per bit", L, 144);
        repeat (40) @(negedge clk);
        wr(2, mk_mode(0,0,0,0,0,0,1,0,0)); repeat (40) @(negedge clk);
        fork send_tx(8'h00); low_run(L); join
        chk(L >= 35 && L <= 37, "R3 four ticks per bit", L, 36);
        repeat (40) @(negedge clk);

        // Stop-bit count seen through busy time (4 ticks per bit)
        for (int sb = 0; sb < 2; sb++) begin
            wr(2, mk_mode(sb[0],0,0,0,0,0,1,0,0)); repeat (20) @(negedge clk);
            send_tx(8'hFF);
            L = 1;
            while (!tx_ready && L < 500) begin @(negedge clk); L++; end
            chk(L >= (10+sb)*4 - 1 && L <= (10+sb)*4 + 1, "R4 R12 frame length by stop count",
                L, (10+sb)*4);
        end
        send_tx(8'h55); @(negedge clk);
        chk(tx_ready == 1'b0, "R12 busy during frame", tx_ready, 0);
        repeat (80) @(negedge clk);

        // Carrier behaviour at idle
        wr(3, 16'd3);
        wr(2, mk_mode(0,0,0,0,0,0,0,1,1)); repeat (8) @(negedge clk);
        count_toggles(64, tg);
        chk(tg >= 15 && tg <= 17, "R6 carrier on high level", tg, 16);
        wr(2, mk_mode(0,0,0,0,0,0,0,1,0)); repeat (8) @(negedge clk);
        count_toggles(64, tg);
        chk(tg == 0 && tx_pin == 1'b1, "R6 high level steady in low-phase mode", tg, 0);
        wr(2, mk_mode(0,0,0,0,0,0,0,0,1)); repeat (8) @(negedge clk);
        count_toggles(64, tg);
        chk(tg == 0 && tx_pin == 1'b1, "R5 no carrier when disabled", tg, 0);
        wr(2, mk_mode(0,0,0,0,1,0,0,1,1)); repeat (8) @(negedge clk);
        count_toggles(64, tg);
        chk(tg >= 15 && tg <= 17, "R7 inverted output still carries", tg, 16);
        wr(2, mk_mode(0,0,0,0,1,0,0,0,0)); repeat (8) @(negedge clk);
        chk(tx_pin == 1'b0, "R7 inverted idle pin", tx_pin, 0);

        // Random frames in loopback
        loop_on = 1'b1;
        for (int it = 0; it < 24; it++) begin
            l7 = 1'($urandom); pe = 1'($urandom); po = 1'($urandom);
            s2 = 1'($urandom); fq = 1'($urandom); iv = 1'($urandom);
            em = 8'($urandom);
            T = fq ? 4 : 16;
            wr(2, mk_mode(s2, po, pe, l7, iv, iv, fq, 0, 0));
            repeat (3*T) @(negedge clk);
            fork
                send_tx(em);
                cap_tx(T, l7, pe, iv, cd, cp, cs, ok);
                wait_rx(T, got, gd, gfe, gpe);
            join
            if (l7) em = em & 8'h7F;
            chk(ok && cd == em, "R4 R7 transmitted data", cd, em);
            if (pe) chk(cp == exp_par(em, l7, po), "R4 transmitted parity", cp, exp_par(em, l7, po));
            chk(cs == 1'b1, "R4 stop level", cs, 1);
            chk(got && gd == em, "R8 received data", gd, em);
            chk(!gfe && !gpe, "R9 R10 clean frame flags", {gfe, gpe}, 0);
            repeat (2*T) @(negedge clk);
        end
        loop_on = 1'b0;

        // Directed receive cases from the bench driver
        wr(2, mk_mode(0,0,1,0,0,0,0,0,0)); repeat (40) @(negedge clk);
        fork drive_rx(16, 8'hA5, 0, 1, 0, 0, 1'b0, 0); wait_rx(16, got, gd, gfe, gpe); join
        chk(got && gfe, "R9 low stop flagged", gfe, 1);
        repeat (40) @(negedge clk);
        fork drive_rx(16, 8'h3C, 0, 1, 0, 1, 1'b1, 0); wait_rx(16, got, gd, gfe, gpe); join
        chk(got && gpe && !gfe, "R10 bad even parity flagged", gpe, 1);
        repeat (40) @(negedge clk);
        wr(2, mk_mode(0,1,1,1,0,1,1,0,0)); drv_rx = 1'b0; repeat (40) @(negedge clk);
        fork drive_rx(4, 8'h6B, 1, 1, 1, 0, 1'b1, 1); wait_rx(4, got, gd, gfe, gpe); join
        chk(got && gd == 8'h6B && !gpe && !gfe, "R7 R8 inverted input 7-bit odd", gd, 8'h6B);
        repeat (20) @(negedge clk);
        fork drive_rx(4, 8'h11, 1, 1, 1, 1, 1'b1, 1); wait_rx(4, got, gd, gfe, gpe); join
        chk(got && gpe, "R10 bad odd parity flagged", gpe, 1);
        repeat (20) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule